// File: doc/BRIEF.md
# Programmable Divide-by-N Down-Counter

This block divides its clock by a programmable integer N and emits an output pulse once per N clocks. It is a down-counter with mixed radices. A fast first section has a modulus chosen by a three-bit mode code (2, 4, 5, 8 or 10). Behind it sit three cascaded decimal digit stages and, in the narrower first-section modes, a "last" stage built from the spare upper bits of the low jam nibble. Each time the first section wraps, it borrows one from the combined value of the digits and the last stage. The start count is therefore modulus × (1000·last + 100·digit2 + 10·digit1 + digit0) + first.

The sixteen jam bits are sampled only when the count is loaded. A hold code parks the counter in a preset state. After the hold is released, one arming clock passes before counting starts. During normal running the counter reloads itself on every terminal count. A latch-enable input can make the output stick high once a pulse has occurred. Typical uses are dividing a synthesizer feedback clock and building a timeout timer.

Top module: `divn_counter`

## Requirements
- R1: The mode code is `mode_k` = {a,b,c}. The counting codes are 110 for ÷10, 010 for ÷8, 101 for ÷5, 001 for ÷4, and 111 or 011 for ÷2. Any code with b=c=0 is the hold code.
- R2: The first section takes `jam[3:0]` masked to 4 bits (÷10), 3 bits (÷8, ÷5), 2 bits (÷4) or 1 bit (÷2). A first value at or above the modulus is reduced by the modulus. The unused upper bits of `jam[3:0]` form the last stage, which has a place value of 1000. ÷10 has no last stage.
- R3: `jam[7:4]`, `jam[11:8]` and `jam[15:12]` preset digits with place values 1, 10 and 100. Any 4-bit value up to 15 is accepted. A digit that borrows at zero wraps to 9.
- R4: Once running, the output pulse repeats every N clocks, where N is given by the formula above, for any N of 3 or more. With latch disabled, each pulse is one clock wide.
- R5: When the count is terminal, the counter reloads from the jam bits present at that clock edge and continues without a gap.
- R6: While the hold code is applied, the output is forced low on the next clock and the counter stays preset. A hold that starts on the terminal clock suppresses that pulse.
- R7: After the hold is released, the first edge only arms the counter. The first pulse therefore appears N+1 clocks after release.
- R8: With `latch_en`=1, the output stays high after a pulse until `latch_en` is 0 at a clock edge. A terminal count in that same edge produces a fresh one-clock pulse.
- R9: While `rst_n` is low, the output is low and the counter is disarmed.
- R10: Changes to the jam bits between reloads have no effect on the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mode_k | input | 3 | Mode code {a,b,c}; b=c=0 selects hold |
| jam | input | 16 | Preset value: first/last nibble, then three digits |
| latch_en | input | 1 | Keeps the output high after a pulse while set |
| pulse_out | output | 1 | Divided output pulse |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the terminal count lands on the edge where `latch_en` drops. In the second, the terminal count lands on the edge where the hold code is applied. The bench uses its own count to find the clock just before terminal, then changes the control input so that both effects meet at one edge. The result is judged against the reference model cycle by cycle: the first case must give exactly one more high cycle, and the second must give a low output with no pulse.

// File: rtl/divn_pkg.sv
package divn_pkg;

  typedef enum logic [2:0] {
    DM_HOLD = 3'd0,
    DM_10   = 3'd1,
    DM_8    = 3'd2,
    DM_5    = 3'd3,
    DM_4    = 3'd4,
    DM_2    = 3'd5
  } div_mode_e;

  // {a,b,c}: b=c=0 is hold regardless of a
  function automatic div_mode_e decode_k(input logic [2:0] k);
    div_mode_e m;
    if (k[1:0] == 2'b00) m = DM_HOLD;
    else begin
      case (k)
        3'b110:  m = DM_10;
        3'b010:  m = DM_8;
        3'b101:  m = DM_5;
        3'b001:  m = DM_4;
        default: m = DM_2;
      endcase
    end
    return m;
  endfunction

  function automatic int first_modulus(input div_mode_e m);
    case (m)
      DM_10:   return 10;
      DM_8:    return 8;
      DM_5:    return 5;
      DM_4:    return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int first_width(input div_mode_e m);
    case (m)
      DM_10:       return 4;
      DM_8, DM_5:  return 3;
      DM_4:        return 2;
      default:     return 1;
    endcase
  endfunction

endpackage

// File: rtl/divn_first_stage.sv
module divn_first_stage
  import divn_pkg::*;
#(
  parameter int FS_W = 4,
  parameter int LS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  div_mode_e       mode,
  input  logic [FS_W-1:0] jam_lo,
  output logic [LS_W-1:0] ls_init,
  output logic            borrow_out,
  output logic            le_one
);

  logic [FS_W-1:0] fs_q, fs_d, modv, raw, mask;
  logic            fs_en;
  int              nb;

  always_comb begin
    nb      = first_width(mode);
    modv    = FS_W'(first_modulus(mode));
    mask    = FS_W'((1 << nb) - 1);
    raw     = jam_lo & mask;
    ls_init = LS_W'(jam_lo >> nb);
    fs_en   = load | step;
    if (load)              fs_d = (raw >= modv) ? raw - modv : raw;
    else if (fs_q == '0)   fs_d = modv - 1'b1;
    else                   fs_d = fs_q - 1'b1;
    borrow_out = step & (fs_q == '0);
    le_one     = (fs_q <= FS_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fs_q <= '0;
    else if (fs_en) fs_q <= fs_d;
  end

  // R2: after a load the first section never sits at or above the modulus
  p_first_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (fs_q < modv || mode != $past(mode)));

endmodule

// File: rtl/divn_decade.sv
module divn_decade #(
  parameter int DIG_W = 4,
  parameter int RADIX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_in,
  input  logic [DIG_W-1:0] jam_dig,
  output logic             borrow_out,
  output logic             is_zero
);

  logic [DIG_W-1:0] dig_q, dig_d;
  logic             dig_en;

  always_comb begin
    dig_en = load | step_in;
    if (load)               dig_d = jam_dig;
    else if (dig_q == '0)   dig_d = DIG_W'(RADIX - 1);
    else                    dig_d = dig_q - 1'b1;
    borrow_out = step_in & (dig_q == '0);
    is_zero    = (dig_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dig_q <= '0;
    else if (dig_en) dig_q <= dig_d;
  end

  p_digit_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_in && !load && is_zero) |=> (dig_q == DIG_W'(RADIX - 1)));

endmodule

// File: rtl/divn_last_stage.sv
module divn_last_stage #(
  parameter int LS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step_in,
  input  logic [LS_W-1:0] ls_init,
  output logic            is_zero
);

  logic [LS_W-1:0] ls_q, ls_d;
  logic            ls_en;

  always_comb begin
    ls_en = load | step_in;
    if (load) ls_d = ls_init;
    else      ls_d = ls_q - 1'b1;
    is_zero = (ls_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ls_q <= '0;
    else if (ls_en) ls_q <= ls_d;
  end

  // R2: a borrow never reaches an empty last stage
  p_last_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_in |-> !is_zero);

endmodule

// File: rtl/divn_counter.sv
module divn_counter
  import divn_pkg::*;
#(
  parameter  int FS_W  = 4,
  parameter  int LS_W  = 3,
  parameter  int NDEC  = 3,
  parameter  int DIG_W = 4,
  localparam int JAM_W = FS_W + NDEC * DIG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_k,
  input  logic [JAM_W-1:0] jam,
  input  logic             latch_en,
  output logic             pulse_out
);

  div_mode_e       mode;
  logic            hold, term, load, step;
  logic            armed_q, armed_d, pulse_q, pulse_d;
  logic            fs_borrow, fs_le1, ls_zero, upper_zero;
  logic [LS_W-1:0] ls_init;
  logic [NDEC:0]   chain;
  logic [NDEC-1:0] dec_zero;

  always_comb begin
    mode       = decode_k(mode_k);
    hold       = (mode == DM_HOLD);
    upper_zero = (&dec_zero) & ls_zero;
    term       = armed_q & upper_zero & fs_le1;
    load       = hold | ~armed_q | term;
    step       = ~hold & armed_q & ~term;
    armed_d    = ~hold;
    pulse_d    = ~hold & (term | (latch_en & pulse_q));
  end

  divn_first_stage #(.FS_W(FS_W), .LS_W(LS_W)) u_first (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .mode(mode),
    .jam_lo(jam[FS_W-1:0]), .ls_init(ls_init),
    .borrow_out(fs_borrow), .le_one(fs_le1)
  );

  assign chain[0] = fs_borrow;

  for (genvar i = 0; i < NDEC; i++) begin : g_digit
    divn_decade #(.DIG_W(DIG_W), .RADIX(10)) u_dig (
      .clk(clk), .rst_n(rst_n), .load(load), .step_in(chain[i]),
      .jam_dig(jam[FS_W + i*DIG_W +: DIG_W]),
      .borrow_out(chain[i+1]), .is_zero(dec_zero[i])
    );
  end

  divn_last_stage #(.LS_W(LS_W)) u_last (
    .clk(clk), .rst_n(rst_n), .load(load), .step_in(chain[NDEC]),
    .ls_init(ls_init), .is_zero(ls_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_out = pulse_q;

  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !pulse_out);

  p_latch_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && pulse_out && !hold) |=> pulse_out);

  p_arm_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> !pulse_out);

  p_hold_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !armed_q);

endmodule

// File: tb/divn_counter_test.sv
`timescale 1ns/1ps
module divn_counter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode_k;
  logic [15:0] jam;
  logic        latch_en;
  logic        pulse_out;

  int    n_checks = 0;
  int    n_err    = 0;
  int    cyc      = 0;
  string phase    = "R9";

  // reference model state
  int m_cnt   = 0;
  bit m_armed = 0;
  bit m_out   = 0;

  always #2 clk = ~clk;

  divn_counter uut (
    .clk(clk), .rst_n(rst_n), .mode_k(mode_k), .jam(jam),
    .latch_en(latch_en), .pulse_out(pulse_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  function automatic bit is_hold(input logic [2:0] k);
    return (k[1:0] == 2'b00);
  endfunction

  function automatic int ratio(input logic [2:0] k, input logic [15:0] j);
    int m, w, f, l, up;
    case (k)
      3'b110:  begin m = 10; w = 4; end
      3'b010:  begin m = 8;  w = 3; end
      3'b101:  begin m = 5;  w = 3; end
      3'b001:  begin m = 4;  w = 2; end
      default: begin m = 2;  w = 1; end
    endcase
    f = int'(j[3:0]) % (1 << w);
    if (f >= m) f = f - m;
    l = int'(j[3:0]) >> w;
    up = 1000*l + 100*int'(j[15:12]) + 10*int'(j[11:8]) + int'(j[7:4]);
    return m*up + f;
  endfunction

  task automatic tick();
    bit term;
    @(posedge clk);
    if (!rst_n) begin
      m_armed = 0; m_out = 0; m_cnt = 0;
    end else if (is_hold(mode_k)) begin
      m_armed = 0; m_out = 0;
    end else if (!m_armed) begin
      m_armed = 1;
      m_out   = latch_en & m_out;
      m_cnt   = ratio(mode_k, jam);
    end else begin
      term  = (m_cnt <= 1);
      m_out = term | (latch_en & m_out);
      m_cnt = term ? ratio(mode_k, jam) : m_cnt - 1;
    end
    @(negedge clk);
    n_checks++;
    if (pulse_out !== m_out) begin
      n_err++;
      $display("FAIL %s: pulse_out=%0b expected %0b at cycle %0d", phase, pulse_out, m_out, cyc);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic until_terminal();
    while (!(m_armed && m_cnt == 1)) tick();
  endtask

  task automatic preset(input logic [15:0] j);
    mode_k = 3'b000; jam = j;
    run(3);
  endtask

  initial begin
    rst_n = 1'b0; mode_k = 3'b000; jam = 16'h0000; latch_en = 1'b0;
    @(negedge clk);
    phase = "R9"; run(3);                        // R9 reset state
    rst_n = 1'b1;

    phase = "R6"; jam = 16'h0125; run(4);        // R6 hold with a=0
    mode_k = 3'b100; run(3);                     // R6 hold with a=1

    phase = "R7"; preset(16'h0032);              // R1 R7: /10, N = 32
    mode_k = 3'b110; run(40);
    phase = "R4"; run(70);

    phase = "R10"; jam = 16'h0012; run(20);      // R10 mid-period change
    phase = "R5"; run(40);                       // R5 reload takes new jam

    phase = "R4"; preset(16'h0003); mode_k = 3'b110; run(15); // N = 3

    phase = "R8"; preset(16'h0005); mode_k = 3'b110;
    latch_en = 1'b1; run(20);
    until_terminal(); latch_en = 1'b0; tick();   // R8 release meets terminal
    run(12);

    phase = "R6"; until_terminal(); mode_k = 3'b000; run(4); // R6 hold meets terminal

    phase = "R1"; preset(16'h0026); mode_k = 3'b010; run(50);  // R1 /8: 8*2+6
    preset(16'h0041); mode_k = 3'b011; run(30);                // R1 /2: 2*4+1

    phase = "R3"; preset(16'h0CF3); mode_k = 3'b001; run(1200); // R3 digits 15,12

    phase = "R2"; preset(16'h0007); mode_k = 3'b111; run(6010); // R2 /2, last=3
    preset(16'h000F); mode_k = 3'b101; run(5010);               // R2 /5, first 7 -> 2
    preset(16'h000C); mode_k = 3'b110; run(30);                 // R2 /10, first 12 -> 2

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule